// File: doc/BRIEF.md
# Trigger and Request Interrupt Frame Generator

This block sits beside the command executor of a crate controller and generates unsolicited 64-bit reply frames. It watches two sources. The first is an asynchronous trigger input. Each accepted trigger advances a 32-bit event counter and raises a busy-out veto line. The second is a 24-bit look-at-me request pattern from the modules in the crate. A trigger produces a frame that carries the new event count. A rising request condition produces a frame that carries the request pattern.

Interrupt frames share the reply path with the command executor. The executor raises `pkt_active` for as long as it is working through a packet. While that line is high the block only collects events and never starts a frame, so an executor packet is never split. Held frames go out after the packet completes. A trigger frame goes out before a request frame. Busy-out is dropped only by an explicit clear from the executor. The event count can be read at all times and can be zeroed by command.

Top module: `irq_frame_gen`

## Requirements
- R1: Each accepted trigger adds exactly one to `event_count`. The count wraps modulo 2^32.
- R2: A trigger frame has header 0xA1 in bits 63:56, the event count after the increment in bits 31:0, and zeros in bits 55:32.
- R3: An accepted trigger sets `busy_out`, which stays high until a `busy_clr` pulse. A trigger edge is ignored and not counted while `busy_out` is high or while an earlier trigger frame has not yet been issued.
- R4: A request frame has header 0xA2 in bits 63:56, the request pattern in bits 23:0, and zeros in bits 55:24. The pattern is sampled in the cycle the OR of the pattern goes from 0 to 1. Exactly one frame is raised per such rise. Changes to the pattern while it stays nonzero raise no frame.
- R5: `req_any` is high in the same cycle that any bit of `req_pat` is high, with no register delay.
- R6: `frame_valid` never rises in a cycle that follows a cycle with `pkt_active` high. Events that arrive during a packet are held and issued after `pkt_active` falls.
- R7: When a trigger frame and a request frame are both waiting, the trigger frame is issued first.
- R8: A frame is transferred on a clock edge where `frame_valid` and `frame_ready` are both high. Until that edge, `frame_valid` and `frame_data` hold steady.
- R9: A `cnt_clr` pulse sets `event_count` to zero. If a trigger is accepted in the same cycle, the count becomes one.
- R10: After reset, `frame_valid`, `busy_out` and `event_count` are all zero.
- R11: The trigger is synchronized through two flip-flop stages and counted only on a rising edge. A level held high is counted once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 1 | Asynchronous trigger input |
| req_pat | input | 24 | Look-at-me request pattern |
| pkt_active | input | 1 | Executor is processing a packet |
| busy_clr | input | 1 | Executor command that releases busy-out |
| cnt_clr | input | 1 | Command that zeroes the event count |
| frame_ready | input | 1 | Reply path accepts a frame |
| frame_valid | output | 1 | Interrupt frame offered |
| frame_data | output | 64 | Interrupt frame: header and payload |
| busy_out | output | 1 | Trigger veto line |
| req_any | output | 1 | Some request bit is active |
| event_count | output | 32 | Current event count |

## Verification
The checker watches a set of rules on every cycle:
- the count only steps by one, and only while busy is low;
- busy stays latched until `busy_clr`;
- no frame starts just after a cycle with `pkt_active` high;
- a frame offered on the reply path stays stable under backpressure;
- every frame has a legal header and zero padding.

Some behaviours only the bench scenarios can show:
- the order of a trigger frame and a request frame that were held back by a packet;
- that a long trigger level or a second edge under busy produces no extra frame;
- that a request pattern which changes while still active stays silent;
- the exact count carried in each frame.

// File: rtl/irq_frame_pkg.sv
package irq_frame_pkg;
   localparam int FRAME_W = 64;
   localparam int HDR_W   = 8;
   localparam int PAY_W   = FRAME_W - HDR_W;

   typedef enum logic [HDR_W-1:0] {
      HDR_TRIG = 8'hA1,
      HDR_REQ  = 8'hA2
   } frame_hdr_e;

   function automatic logic [FRAME_W-1:0] pack_frame(frame_hdr_e hdr, logic [PAY_W-1:0] pay);
      return {hdr, pay};
   endfunction
endpackage

// File: rtl/trig_edge_det.sv
module trig_edge_det #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              last_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/trig_count_busy.sv
module trig_count_busy #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   input  logic             hold_off,
   input  logic             busy_clr,
   input  logic             cnt_clr,
   output logic             accept,
   output logic [CNT_W-1:0] next_count,
   output logic [CNT_W-1:0] count,
   output logic             busy
);
   assign accept     = rise & ~busy & ~hold_off;
   assign next_count = cnt_clr ? CNT_W'(1) : count + CNT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (cnt_clr) begin
         count <= accept ? CNT_W'(1) : '0;
      end else if (accept) begin
         count <= next_count;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        busy <= 1'b0;
      else if (accept)   busy <= 1'b1;
      else if (busy_clr) busy <= 1'b0;
   end
endmodule

// File: rtl/req_rise_det.sv
module req_rise_det #(
   parameter int REQ_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REQ_W-1:0] pat,
   output logic             any,
   output logic             rise
);
   logic any_q;

   assign any  = |pat;
   assign rise = any & ~any_q;

   always_ff @(posedge clk) begin
      if (!rst_n) any_q <= 1'b0;
      else        any_q <= any;
   end
endmodule

// File: rtl/frame_arbiter.sv
module frame_arbiter
   import irq_frame_pkg::*;
#(
   parameter int CNT_W = 32,
   parameter int REQ_W = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trig_evt,
   input  logic [CNT_W-1:0]   trig_cnt,
   input  logic               req_evt,
   input  logic [REQ_W-1:0]   req_pat,
   input  logic               pkt_active,
   input  logic               frame_ready,
   output logic               trig_pend,
   output logic               frame_valid,
   output logic [FRAME_W-1:0] frame_data
);
   logic [CNT_W-1:0] trig_hold;
   logic [REQ_W-1:0] req_hold;
   logic             req_pend;
   logic             launch, take_trig, take_req;
   logic [PAY_W-1:0] trig_pay, req_pay;

   assign launch    = ~frame_valid & ~pkt_active;
   assign take_trig = launch & trig_pend;
   assign take_req  = launch & ~trig_pend & req_pend;

   always_comb begin
      trig_pay = '0;
      trig_pay[CNT_W-1:0] = trig_hold;
      req_pay = '0;
      req_pay[REQ_W-1:0] = req_hold;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trig_pend <= 1'b0;
         trig_hold <= '0;
      end else if (trig_evt) begin
         trig_pend <= 1'b1;
         trig_hold <= trig_cnt;
      end else if (take_trig) begin
         trig_pend <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_pend <= 1'b0;
         req_hold <= '0;
      end else if (req_evt && (!req_pend || take_req)) begin
         req_pend <= 1'b1;
         req_hold <= req_pat;
      end else if (take_req) begin
         req_pend <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_valid <= 1'b0;
         frame_data  <= '0;
      end else if (frame_valid && frame_ready) begin
         frame_valid <= 1'b0;
      end else if (take_trig) begin
         frame_valid <= 1'b1;
         frame_data  <= pack_frame(HDR_TRIG, trig_pay);
      end else if (take_req) begin
         frame_valid <= 1'b1;
         frame_data  <= pack_frame(HDR_REQ, req_pay);
      end
   end
endmodule

// File: rtl/irq_frame_gen.sv
module irq_frame_gen
   import irq_frame_pkg::*;
#(
   parameter int CNT_W       = 32,
   parameter int REQ_W       = 24,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trig_in,
   input  logic [REQ_W-1:0]   req_pat,
   input  logic               pkt_active,
   input  logic               busy_clr,
   input  logic               cnt_clr,
   input  logic               frame_ready,
   output logic               frame_valid,
   output logic [FRAME_W-1:0] frame_data,
   output logic               busy_out,
   output logic               req_any,
   output logic [CNT_W-1:0]   event_count
);
   if (CNT_W >= PAY_W || REQ_W >= PAY_W || SYNC_STAGES < 2) begin : g_bad_cfg
      $error("irq_frame_gen: payload fields exceed frame or synchronizer too short");
   end

   logic             trig_rise, trig_acc, trig_pend, req_rise;
   logic [CNT_W-1:0] cnt_next;

   trig_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .async_in(trig_in), .rise(trig_rise)
   );

   trig_count_busy #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .rise(trig_rise), .hold_off(trig_pend),
      .busy_clr(busy_clr), .cnt_clr(cnt_clr), .accept(trig_acc),
      .next_count(cnt_next), .count(event_count), .busy(busy_out)
   );

   req_rise_det #(.REQ_W(REQ_W)) u_req (
      .clk(clk), .rst_n(rst_n), .pat(req_pat), .any(req_any), .rise(req_rise)
   );

   frame_arbiter #(.CNT_W(CNT_W), .REQ_W(REQ_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .trig_evt(trig_acc), .trig_cnt(cnt_next),
      .req_evt(req_rise), .req_pat(req_pat), .pkt_active(pkt_active),
      .frame_ready(frame_ready), .trig_pend(trig_pend),
      .frame_valid(frame_valid), .frame_data(frame_data)
   );
endmodule

// File: rtl/irq_frame_gen_chk.sv
module irq_frame_gen_chk
   import irq_frame_pkg::*;
#(
   parameter int CNT_W = 32,
   parameter int REQ_W = 24
) (
   input logic               clk,
   input logic               rst_n,
   input logic               pkt_active,
   input logic               busy_clr,
   input logic               cnt_clr,
   input logic               frame_ready,
   input logic               frame_valid,
   input logic [FRAME_W-1:0] frame_data,
   input logic               busy_out,
   input logic [CNT_W-1:0]   event_count
);
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_clr |=> (event_count == $past(event_count) || event_count == $past(event_count) + 1'b1)); // R1
   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      busy_out && !busy_clr |=> busy_out); // R3
   AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      busy_out && !cnt_clr |=> $stable(event_count)); // R3
   AST_CNT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clr |=> event_count <= CNT_W'(1)); // R9
   AST_LAUNCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_valid) |-> !$past(pkt_active)); // R6
   AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid && !frame_ready |=> frame_valid && $stable(frame_data)); // R8
   AST_HDR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |-> (frame_data[FRAME_W-1 -: HDR_W] == HDR_TRIG || frame_data[FRAME_W-1 -: HDR_W] == HDR_REQ)); // R2
   AST_TRIG_PAD: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid && frame_data[FRAME_W-1 -: HDR_W] == HDR_TRIG |-> frame_data[PAY_W-1:CNT_W] == '0); // R2
   AST_REQ_PAD: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid && frame_data[FRAME_W-1 -: HDR_W] == HDR_REQ |-> frame_data[PAY_W-1:REQ_W] == '0); // R4
endmodule

bind irq_frame_gen irq_frame_gen_chk #(.CNT_W(CNT_W), .REQ_W(REQ_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pkt_active(pkt_active), .busy_clr(busy_clr),
   .cnt_clr(cnt_clr), .frame_ready(frame_ready), .frame_valid(frame_valid),
   .frame_data(frame_data), .busy_out(busy_out), .event_count(event_count)
);

// File: tb/irq_frame_gen_tb.sv
`timescale 1ns/100ps
module irq_frame_gen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trig_in = 1'b0;
   logic [23:0] req_pat = '0;
   logic        pkt_active = 1'b0;
   logic        busy_clr = 1'b0;
   logic        cnt_clr = 1'b0;
   logic        frame_ready = 1'b1;
   logic        frame_valid;
   logic [63:0] frame_data;
   logic        busy_out;
   logic        req_any;
   logic [31:0] event_count;

   int          n_checks = 0;
   int          n_errors = 0;
   logic [63:0] exp_q[$];

   always #2.5 clk = ~clk;

   irq_frame_gen u_dut (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .req_pat(req_pat),
      .pkt_active(pkt_active), .busy_clr(busy_clr), .cnt_clr(cnt_clr),
      .frame_ready(frame_ready), .frame_valid(frame_valid), .frame_data(frame_data),
      .busy_out(busy_out), .req_any(req_any), .event_count(event_count)
   );

   function automatic logic [63:0] trig_frame(logic [31:0] c);
      return {8'hA1, 24'h0, c};
   endfunction
   function automatic logic [63:0] req_frame(logic [23:0] p);
      return {8'hA2, 32'h0, p};
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_trig();
      trig_in = 1'b1; tick(3); trig_in = 1'b0; tick(2);
   endtask

   task automatic pulse_busy_clr();
      busy_clr = 1'b1; tick(1); busy_clr = 1'b0; tick(1);
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   endtask

   // Monitor: pops the scoreboard at each transfer, sampled just before the edge
   initial begin
      forever begin
         @(negedge clk); #2;
         if (rst_n && frame_valid && frame_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R3/R4 unexpected frame", frame_data, 64'h0);
            end else begin
               logic [63:0] e;
               e = exp_q.pop_front();
               check(frame_data == e, "R2/R4/R7 frame content", frame_data, e);
            end
         end
      end
   end

   task automatic drain(input string req);
      int waited = 0;
      while (exp_q.size() != 0 && waited < 200) begin tick(1); waited++; end
      tick(3);
      check(exp_q.size() == 0, req, 64'(exp_q.size()), 64'h0);
   endtask

   initial begin
      #1_000_000;
      check(1'b0, "watchdog expired", 64'h0, 64'h0);
      report();
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R10 reset state
      check(frame_valid == 1'b0, "R10 frame_valid", 64'(frame_valid), 64'h0);
      check(busy_out == 1'b0, "R10 busy_out", 64'(busy_out), 64'h0);
      check(event_count == 32'h0, "R10 event_count", 64'(event_count), 64'h0);

      // R1 R2 R11: first trigger
      exp_q.push_back(trig_frame(32'd1));
      pulse_trig(); tick(6);
      check(event_count == 32'd1, "R1 count after first trigger", 64'(event_count), 64'd1);
      check(busy_out == 1'b1, "R3 busy set", 64'(busy_out), 64'h1);
      drain("R2 trigger frame delivered");

      // R3: edge while busy is ignored
      pulse_trig(); tick(6);
      check(event_count == 32'd1, "R3 edge ignored while busy", 64'(event_count), 64'd1);
      check(frame_valid == 1'b0, "R3 no frame while busy", 64'(frame_valid), 64'h0);
      pulse_busy_clr();
      check(busy_out == 1'b0, "R3 busy released", 64'(busy_out), 64'h0);

      // R11: long level counts once
      exp_q.push_back(trig_frame(32'd2));
      trig_in = 1'b1; tick(6);
      pulse_busy_clr(); tick(8);
      trig_in = 1'b0; tick(4);
      check(event_count == 32'd2, "R11 held level counted once", 64'(event_count), 64'd2);
      drain("R11 single frame for held level");

      // R4 R5: request pattern
      req_pat = 24'h008001; #1;
      check(req_any == 1'b1, "R5 req_any same cycle", 64'(req_any), 64'h1);
      exp_q.push_back(req_frame(24'h008001));
      tick(6);
      req_pat = 24'h000100; tick(6);
      drain("R4 one frame while pattern stays active");
      req_pat = 24'h0; #1;
      check(req_any == 1'b0, "R5 req_any clear", 64'(req_any), 64'h0);
      tick(3);
      exp_q.push_back(req_frame(24'h800000));
      req_pat = 24'h800000; tick(4);
      req_pat = 24'h0;
      drain("R4 new frame on new rise");

      // R6 R7: events during a packet held back, trigger first
      pkt_active = 1'b1; tick(1);
      pulse_busy_clr();
      req_pat = 24'h0000FF;
      pulse_trig(); tick(8);
      check(frame_valid == 1'b0, "R6 no frame during packet", 64'(frame_valid), 64'h0);
      check(event_count == 32'd3, "R1 count during packet", 64'(event_count), 64'd3);
      exp_q.push_back(trig_frame(32'd3));
      exp_q.push_back(req_frame(24'h0000FF));
      pkt_active = 1'b0;
      drain("R7 trigger then request after packet");
      req_pat = 24'h0;

      // R8: backpressure
      pulse_busy_clr();
      frame_ready = 1'b0;
      pulse_trig(); tick(6);
      check(frame_valid == 1'b1, "R8 valid under backpressure", 64'(frame_valid), 64'h1);
      check(frame_data == trig_frame(32'd4), "R8 data under backpressure", frame_data, trig_frame(32'd4));
      tick(5);
      check(frame_valid == 1'b1 && frame_data == trig_frame(32'd4), "R8 held steady", frame_data, trig_frame(32'd4));
      exp_q.push_back(trig_frame(32'd4));
      frame_ready = 1'b1;
      drain("R8 frame released");

      // R9: count clear
      pulse_busy_clr();
      cnt_clr = 1'b1; tick(1); cnt_clr = 1'b0; tick(1);
      check(event_count == 32'd0, "R9 count cleared", 64'(event_count), 64'h0);
      exp_q.push_back(trig_frame(32'd1));
      pulse_trig(); tick(6);
      check(event_count == 32'd1, "R9 count restarts", 64'(event_count), 64'd1);
      drain("R9 frame after clear");

      report();
   end
endmodule